// File: doc/BRIEF.md
# Dual-Lane Register Bank

This block holds a parameterised array of 32-bit control registers behind a 64-bit host bus. Every 64-bit word address covers a pair of registers, even and odd. A lane-select mask sent with each access picks one of the pair. The selected register travels in the half of the data bus that matches its lane, and the other half is not used.

Host writes never replace a register. They OR the incoming bits into it, so a host can only set bits. A companion engine inside the chip has two ports of its own. A combinational read port lets it watch any register. A force port lets it load any register with a value of its choosing, which is how it clears status bits that the host has set.

At reset every register returns to zero, except for a few preset values. A parameter picks the preset set: none, a bus-version set, or an identity/revision set. Host accesses take one cycle. The bus is always ready, and read data appears one cycle after the read is accepted.

Top module: `lanereg_bank`

## Requirements
- R1: With the bus-version preset (the default), reset leaves register 0x27 at 0x00000008 and every other register at zero.
- R2: The register index is the word address times two, plus one for the odd lane. The odd lane is selected only when the lane mask is exactly 0x00000000FFFFFFFF. Any other mask, including all-zeros and all-ones, selects the even lane.
- R3: Read data carries the register in bits 63:32 for the odd lane and in bits 31:0 for the even lane. The half that was not selected reads as zero.
- R4: A host write takes bits 63:32 of the write data for the odd lane and bits 31:0 for the even lane, and ORs them into the selected register. Bits that are already set are never cleared, and the other half of the bus is ignored.
- R5: host_ready is always 1. host_rvalid is 1 exactly in the cycle after an accepted read. The read data is the value the register held before any update made in the same cycle as the read.
- R6: An access whose index is NUM_REGS or above reads as zero. A write to such an index changes no register, and there is no aliasing onto a lower index.
- R7: eng_rdata shows the register at eng_ridx combinationally. An index of NUM_REGS or above reads as zero.
- R8: A force loads eng_frc_value into register eng_frc_idx at the next edge. A host write to the same register in the same cycle ORs its bits on top of the forced value.
- R9: With the identity preset, reset leaves register 0 at 0x17FD11DB, register 1 at 0x00000001, and every other register at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the preset values |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_word_addr | input | ADDR_W | 64-bit word address |
| host_lane_mask | input | 2*REG_W | Lane-select mask |
| host_wdata | input | 2*REG_W | Host write data |
| host_ready | output | 1 | Always 1 |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 2*REG_W | Read data, placed in the lane's half |
| eng_ridx | input | ADDR_W+1 | Engine read index |
| eng_rdata | output | REG_W | Engine read data |
| eng_frc_valid | input | 1 | Engine force request |
| eng_frc_idx | input | ADDR_W+1 | Register to force |
| eng_frc_value | input | REG_W | Value loaded by the force |

## Verification
The assertions assume that each input keeps its value for the whole cycle, and that the engine only samples eng_rdata when eng_ridx has been held over the cycle it cares about. The force and monotonic-set properties check only while eng_ridx is unchanged from one cycle to the next. The bench drives every input at the falling edge and holds eng_ridx steady around each force or write that it observes. It uses only the exact odd-lane mask or masks that are clearly not that value, so lane selection is never ambiguous.

// File: rtl/lanereg_pkg.sv
package lanereg_pkg;

   typedef enum logic [1:0] {
      PRESET_NONE   = 2'd0,
      PRESET_BUSVER = 2'd1,
      PRESET_IDREV  = 2'd2
   } preset_e;

   localparam int          BUSVER_IDX = 'h27;
   localparam logic [31:0] BUSVER_VAL = 32'h0000_0008;
   localparam logic [31:0] IDENT_VAL  = 32'h17FD_11DB;
   localparam logic [31:0] REV_VAL    = 32'h0000_0001;

   // reset value of register idx under preset mode m
   function automatic logic [31:0] preset_value(preset_e m, int idx);
      logic [31:0] v;
      v = '0;
      case (m)
         PRESET_BUSVER: if (idx == BUSVER_IDX) v = BUSVER_VAL;
         PRESET_IDREV: begin
            if (idx == 0) v = IDENT_VAL;
            else if (idx == 1) v = REV_VAL;
         end
         default: v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/lanereg_decode.sv
module lanereg_decode #(
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 7,
   parameter int NUM_REGS = 128,
   localparam int BUS_W   = 2 * REG_W,
   localparam int IDX_W   = ADDR_W + 1
) (
   input  logic [ADDR_W-1:0] word_addr,
   input  logic [BUS_W-1:0]  lane_mask,
   output logic [IDX_W-1:0]  idx,
   output logic              odd,
   output logic              in_range
);
   localparam logic [BUS_W-1:0] ODD_MASK = {{REG_W{1'b0}}, {REG_W{1'b1}}};

   always_comb begin
      odd      = (lane_mask == ODD_MASK);
      idx      = {word_addr, odd};
      in_range = (32'(idx) < 32'(NUM_REGS));
   end
endmodule

// File: rtl/lanereg_lanes.sv
module lanereg_lanes #(
   parameter int REG_W  = 32,
   localparam int BUS_W = 2 * REG_W
) (
   input  logic             odd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [REG_W-1:0] reg_wbits,
   input  logic [REG_W-1:0] reg_rval,
   input  logic             rval_ok,
   output logic [BUS_W-1:0] bus_rdata
);
   always_comb begin
      reg_wbits = odd ? bus_wdata[BUS_W-1:REG_W] : bus_wdata[REG_W-1:0];
      if (!rval_ok)
         bus_rdata = '0;
      else if (odd)
         bus_rdata = {reg_rval, {REG_W{1'b0}}};
      else
         bus_rdata = {{REG_W{1'b0}}, reg_rval};
   end
endmodule

// File: rtl/lanereg_store.sv
module lanereg_store
   import lanereg_pkg::*;
#(
   parameter int      NUM_REGS = 128,
   parameter int      REG_W    = 32,
   parameter int      IDX_W    = 8,
   parameter preset_e PRESET   = PRESET_BUSVER
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_bits,
   input  logic             frc_en,
   input  logic [IDX_W-1:0] frc_idx,
   input  logic [REG_W-1:0] frc_val,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic [REG_W-1:0] rd_a,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic [REG_W-1:0] rd_b
);
   localparam int SEL_W = $clog2(NUM_REGS);
   localparam bool_full = (NUM_REGS == (1 << IDX_W));

   logic [REG_W-1:0]    regs [NUM_REGS];
   logic [NUM_REGS-1:0] w_hit;
   logic [NUM_REGS-1:0] f_hit;

   always_comb begin
      for (int i = 0; i < NUM_REGS; i++) begin
         w_hit[i] = wr_en  && (wr_idx  == IDX_W'(i));
         f_hit[i] = frc_en && (frc_idx == IDX_W'(i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++)
            regs[i] <= REG_W'(preset_value(PRESET, i));
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (w_hit[i] || f_hit[i])
               regs[i] <= (f_hit[i] ? frc_val : regs[i]) | (w_hit[i] ? wr_bits : '0);
         end
      end
   end

   // read ports: a bounds guard is only needed when the index space is larger
   generate
      if (bool_full) begin : g_rd_full
         always_comb begin
            rd_a = regs[rd_a_idx[SEL_W-1:0]];
            rd_b = regs[rd_b_idx[SEL_W-1:0]];
         end
      end else begin : g_rd_guard
         always_comb begin
            rd_a = (32'(rd_a_idx) < 32'(NUM_REGS)) ? regs[rd_a_idx[SEL_W-1:0]] : '0;
            rd_b = (32'(rd_b_idx) < 32'(NUM_REGS)) ? regs[rd_b_idx[SEL_W-1:0]] : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/lanereg_bank.sv
module lanereg_bank
   import lanereg_pkg::*;
#(
   parameter int      REG_W    = 32,
   parameter int      ADDR_W   = 7,
   parameter int      NUM_REGS = 128,
   parameter preset_e PRESET   = PRESET_BUSVER,
   localparam int     BUS_W    = 2 * REG_W,
   localparam int     IDX_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid,
   input  logic              host_write,
   input  logic [ADDR_W-1:0] host_word_addr,
   input  logic [BUS_W-1:0]  host_lane_mask,
   input  logic [BUS_W-1:0]  host_wdata,
   output logic              host_ready,
   output logic              host_rvalid,
   output logic [BUS_W-1:0]  host_rdata,
   input  logic [IDX_W-1:0]  eng_ridx,
   output logic [REG_W-1:0]  eng_rdata,
   input  logic              eng_frc_valid,
   input  logic [IDX_W-1:0]  eng_frc_idx,
   input  logic [REG_W-1:0]  eng_frc_value
);
   initial begin : elab_checks
      if (NUM_REGS < 2 || NUM_REGS > (1 << IDX_W))
         $fatal(1, "NUM_REGS out of range for ADDR_W");
      if (PRESET != PRESET_NONE && REG_W < 32)
         $fatal(1, "presets need REG_W of at least 32");
      if (PRESET == PRESET_BUSVER && NUM_REGS <= BUSVER_IDX)
         $fatal(1, "bus-version preset needs more registers");
   end

   logic [IDX_W-1:0] h_idx;
   logic             h_odd;
   logic             h_in_range;
   logic [REG_W-1:0] h_wbits;
   logic [REG_W-1:0] h_rval;
   logic [BUS_W-1:0] h_rpacked;
   logic             h_wr_en;
   logic             h_rd_en;
   logic             rvalid_q;
   logic [BUS_W-1:0] rdata_q;

   lanereg_decode #(.REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
      .word_addr (host_word_addr),
      .lane_mask (host_lane_mask),
      .idx       (h_idx),
      .odd       (h_odd),
      .in_range  (h_in_range)
   );

   lanereg_lanes #(.REG_W(REG_W)) u_lanes (
      .odd       (h_odd),
      .bus_wdata (host_wdata),
      .reg_wbits (h_wbits),
      .reg_rval  (h_rval),
      .rval_ok   (h_in_range),
      .bus_rdata (h_rpacked)
   );

   always_comb begin
      h_wr_en = host_valid && host_write && h_in_range;
      h_rd_en = host_valid && !host_write;
   end

   lanereg_store #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W), .PRESET(PRESET)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (h_wr_en),
      .wr_idx   (h_idx),
      .wr_bits  (h_wbits),
      .frc_en   (eng_frc_valid),
      .frc_idx  (eng_frc_idx),
      .frc_val  (eng_frc_value),
      .rd_a_idx (h_idx),
      .rd_a     (h_rval),
      .rd_b_idx (eng_ridx),
      .rd_b     (eng_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= h_rd_en;
         if (h_rd_en) rdata_q <= h_rpacked;
      end
   end

   assign host_ready  = 1'b1;
   assign host_rvalid = rvalid_q;
   assign host_rdata  = rdata_q;
endmodule

// File: rtl/lanereg_bank_chk.sv
module lanereg_bank_chk #(
   parameter int  REG_W    = 32,
   parameter int  ADDR_W   = 7,
   parameter int  NUM_REGS = 128,
   localparam int BUS_W    = 2 * REG_W,
   localparam int IDX_W    = ADDR_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_valid,
   input logic             host_write,
   input logic [BUS_W-1:0] host_lane_mask,
   input logic [BUS_W-1:0] host_rdata,
   input logic             host_rvalid,
   input logic [IDX_W-1:0] eng_ridx,
   input logic [REG_W-1:0] eng_rdata,
   input logic             eng_frc_valid,
   input logic [IDX_W-1:0] eng_frc_idx,
   input logic [REG_W-1:0] eng_frc_value
);
   localparam logic [BUS_W-1:0] ODD_MASK = {{REG_W{1'b0}}, {REG_W{1'b1}}};

   p_rvalid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write) |=> host_rvalid);

   p_rvalid_only_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_valid && !host_write) |=> !host_rvalid);

   p_idle_half_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write) |=>
         ($past(host_lane_mask) == ODD_MASK ? host_rdata[REG_W-1:0] == '0
                                            : host_rdata[BUS_W-1:REG_W] == '0));

   p_set_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_frc_valid |=>
         (eng_ridx != $past(eng_ridx)) ||
         ((eng_rdata & $past(eng_rdata)) == $past(eng_rdata)));

   p_force_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_frc_valid && !(host_valid && host_write) && eng_ridx == eng_frc_idx &&
       32'(eng_frc_idx) < 32'(NUM_REGS)) |=>
         (eng_ridx != $past(eng_ridx)) || (eng_rdata == $past(eng_frc_value)));

   p_eng_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(eng_ridx) >= 32'(NUM_REGS)) |-> (eng_rdata == '0));
endmodule

bind lanereg_bank lanereg_bank_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .host_valid     (host_valid),
   .host_write     (host_write),
   .host_lane_mask (host_lane_mask),
   .host_rdata     (host_rdata),
   .host_rvalid    (host_rvalid),
   .eng_ridx       (eng_ridx),
   .eng_rdata      (eng_rdata),
   .eng_frc_valid  (eng_frc_valid),
   .eng_frc_idx    (eng_frc_idx),
   .eng_frc_value  (eng_frc_value)
);

// File: tb/tb_lanereg_bank.sv
module tb_lanereg_bank;
   import lanereg_pkg::*;

   localparam logic [63:0] ODD_M  = 64'h0000_0000_FFFF_FFFF;
   localparam logic [63:0] EVEN_M = 64'hFFFF_FFFF_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0, host_write = 1'b0;
   logic [6:0]  host_word_addr = '0;
   logic [63:0] host_lane_mask = '0, host_wdata = '0;
   logic        host_ready, host_rvalid, id_ready, id_rvalid;
   logic [63:0] host_rdata, id_rdata;
   logic [7:0]  eng_ridx = '0, eng_frc_idx = '0;
   logic [31:0] eng_rdata, id_eng_rdata, eng_frc_value = '0;
   logic        eng_frc_valid = 1'b0;

   int n_tests = 0, n_fail = 0;
   logic [63:0] rd;
   logic        rv;

   always #10 clk = ~clk;

   lanereg_bank dut (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
      .host_word_addr(host_word_addr), .host_lane_mask(host_lane_mask), .host_wdata(host_wdata),
      .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
      .eng_ridx(eng_ridx), .eng_rdata(eng_rdata), .eng_frc_valid(eng_frc_valid),
      .eng_frc_idx(eng_frc_idx), .eng_frc_value(eng_frc_value));

   lanereg_bank #(.PRESET(PRESET_IDREV)) dut_id (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
      .host_word_addr(host_word_addr), .host_lane_mask(host_lane_mask), .host_wdata(host_wdata),
      .host_ready(id_ready), .host_rvalid(id_rvalid), .host_rdata(id_rdata),
      .eng_ridx(eng_ridx), .eng_rdata(id_eng_rdata), .eng_frc_valid(eng_frc_valid),
      .eng_frc_idx(eng_frc_idx), .eng_frc_value(eng_frc_value));

   task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic host_rd(logic [6:0] w, logic [63:0] m);
      @(negedge clk);
      host_valid = 1'b1; host_write = 1'b0; host_word_addr = w; host_lane_mask = m;
      @(negedge clk);
      host_valid = 1'b0;
      rd = host_rdata; rv = host_rvalid;
   endtask

   task automatic host_wr(logic [6:0] w, logic [63:0] m, logic [63:0] d);
      @(negedge clk);
      host_valid = 1'b1; host_write = 1'b1; host_word_addr = w; host_lane_mask = m; host_wdata = d;
      @(negedge clk);
      host_valid = 1'b0; host_write = 1'b0;
   endtask

   task automatic t_reset();
      check("R5", {63'd0, host_ready}, 64'd1, "ready high");
      check("R5", {63'd0, host_rvalid}, 64'd0, "rvalid low at reset");
      host_rd(7'h13, ODD_M);
      check("R1", rd, {32'h8, 32'h0}, "busver reg 0x27");
      check("R9", id_rdata, 64'd0, "idrev reg 0x27 zero");
      host_rd(7'h00, EVEN_M);
      check("R1", rd, 64'd0, "busver reg 0");
      check("R9", id_rdata, {32'h0, 32'h17FD_11DB}, "idrev reg 0");
      host_rd(7'h00, ODD_M);
      check("R9", id_rdata, {32'h1, 32'h0}, "idrev reg 1");
      host_rd(7'h13, EVEN_M);
      check("R1", rd, 64'd0, "busver reg 0x26");
      eng_ridx = 8'h27; #1;
      check("R7", {32'd0, eng_rdata}, 64'h8, "engine read reg 0x27");
   endtask

   task automatic t_lanes();
      eng_ridx = 8'd10;
      host_wr(7'd5, EVEN_M, {32'hDEAD_BEEF, 32'h0000_00F0});
      host_rd(7'd5, EVEN_M);
      check("R4", rd, {32'h0, 32'hF0}, "even write, upper ignored");
      check("R5", {63'd0, rv}, 64'd1, "rvalid after read");
      host_rd(7'd5, ODD_M);
      check("R2", rd, 64'd0, "odd neighbour untouched");
      host_wr(7'd5, EVEN_M, {32'h0, 32'h0000_000F});
      host_wr(7'd5, EVEN_M, 64'd0);
      host_rd(7'd5, EVEN_M);
      check("R4", rd, {32'h0, 32'hFF}, "OR accumulate, never clears");
      host_wr(7'd5, ODD_M, {32'h1234_0000, 32'hCAFE_F00D});
      host_rd(7'd5, ODD_M);
      check("R3", rd, {32'h1234_0000, 32'h0}, "odd lane in upper half");
      host_rd(7'd5, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R2", rd, {32'h0, 32'hFF}, "all-ones mask picks even");
      host_rd(7'd5, 64'd0);
      check("R2", rd, {32'h0, 32'hFF}, "zero mask picks even");
      check("R7", {32'd0, eng_rdata}, 64'hFF, "engine sees reg 10");
   endtask

   task automatic t_force();
      eng_ridx = 8'd10;
      @(negedge clk);
      eng_frc_valid = 1'b1; eng_frc_idx = 8'd10; eng_frc_value = 32'h3;
      @(negedge clk);
      eng_frc_valid = 1'b0;
      check("R8", {32'd0, eng_rdata}, 64'h3, "force loads value");
      // read and force in the same cycle
      @(negedge clk);
      host_valid = 1'b1; host_write = 1'b0; host_word_addr = 7'd5; host_lane_mask = EVEN_M;
      eng_frc_valid = 1'b1; eng_frc_value = 32'h0;
      @(negedge clk);
      host_valid = 1'b0; eng_frc_valid = 1'b0;
      check("R5", host_rdata, {32'h0, 32'h3}, "read returns pre-force value");
      check("R8", {32'd0, eng_rdata}, 64'h0, "force to zero clears");
      // force and host write to the same register in one cycle
      @(negedge clk);
      host_valid = 1'b1; host_write = 1'b1; host_word_addr = 7'd5; host_lane_mask = EVEN_M;
      host_wdata = {32'hFFFF_FFFF, 32'h1};
      eng_frc_valid = 1'b1; eng_frc_value = 32'h100;
      @(negedge clk);
      host_valid = 1'b0; host_write = 1'b0; eng_frc_valid = 1'b0;
      check("R8", {32'd0, eng_rdata}, 64'h101, "host bits OR onto forced value");
      check("R5", {63'd0, host_rvalid}, 64'd0, "no rvalid after write");
   endtask

   task automatic t_range();
      host_wr(7'd100, EVEN_M, {32'h0, 32'hA5A5_A5A5});
      host_rd(7'd100, EVEN_M);
      check("R6", rd, 64'd0, "out-of-range read zero");
      check("R6", {63'd0, rv}, 64'd1, "out-of-range read still valid");
      host_rd(7'd36, EVEN_M);
      check("R6", rd, 64'd0, "no alias onto reg 72");
      eng_ridx = 8'd200; #1;
      check("R7", {32'd0, eng_rdata}, 64'd0, "engine out-of-range zero");
      eng_ridx = 8'd72; #1;
      check("R6", {32'd0, eng_rdata}, 64'd0, "engine view of reg 72");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lanes();
      t_force();
      t_range();
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule